// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the 32-bit full-width instruction that does the same work. Fetch delivers a 32-bit word that holds two halfwords. An endianness select chooses which of the two is the current instruction. The chosen halfword is decoded by its top five bits. Each register number and immediate field is moved into the place the wide encoding expects. The block also scales offsets where the short form implies it, widens register numbers for the high-register forms, and enables two encodings only when a feature option is set.

The expander covers the data-processing groups: shifts by immediate, three-operand add/sub, 8-bit immediate ops, register ALU ops and high-register ops. It also covers every load/store addressing form, stack adjust, push/pop, and multiple load/store. Branches, the long-branch pair, the conditional-branch group and the software trap pattern do not produce a word. They only report a branch status and are left to separate blocks.

Every result carries a two-bit status. When the status is anything other than decoded, the word is forced to a fixed filler value. A parameter chooses between a registered output with one cycle of latency and a purely combinational path.

Top module: `cinstr_expander`

## Requirements
- R1: With big_end_i = 1 the current instruction is fetch_i[31:16]; with big_end_i = 0 it is fetch_i[15:0]. The other halfword has no effect on the result.
- R2: Groups 0–2 (bits [15:11]) expand to 0xE1B00000, with bits [12:11] placed at [6:5], bits [10:6] at [11:7], bits [5:3] at [3:0] and bits [2:0] at [15:12].
- R3: Group 3 picks its base with bits [10:9] (00: 0xE0900000, 01: 0xE0500000, 10: 0xE2900000, 11: 0xE2500000), then places bits [8:6] at [3:0], bits [5:3] at [19:16] and bits [2:0] at [15:12].
- R4: Groups 4–7 pick their base with bits [12:11] (0xE3B00000, 0xE3500000, 0xE2900000, 0xE2500000), then place bits [7:0] at [7:0] and bits [10:8] at both [19:16] and [15:12].
- R5: Group 8 with bit 10 = 0 uses bits [9:6] to choose a base from a 16-entry table and one of four field layouts: normal (rd to [19:16] and [15:12], rs to [3:0]), shift (rd to [15:12] and [3:0], rs to [11:8]), negate (rd to [15:12], rs to [19:16]) and multiply (rd to [19:16] and [11:8], rs to [3:0]).
- R6: Group 8 with bit 10 = 1 forms 4-bit register numbers, {bit 7, bits [2:0]} for the destination and {bit 6, bits [5:3]} for the source. It gives add, compare and move for sub-codes 1–3, 5–7 and 9–11, and an exchange branch (0xE12FFF10) for 12–13. Sub-codes 0, 4 and 8 are undefined. Sub-codes 14–15 give 0xE12FFF30 only when v5_en_i = 1 and are undefined otherwise.
- R7: Group 9 expands to 0xE59F0000 and groups 18/19 to 0xE58D0000 (store) or 0xE59D0000 (load, bit 11). In both, bits [10:8] go to [15:12] and bits [7:0], scaled by 4, to [9:2]. Groups 20/21 expand to 0xE28F0F00 (PC, bit 11 = 0) or 0xE28D0F00 (SP), with bits [10:8] at [15:12] and bits [7:0] unscaled.
- R8: Groups 10/11 with register offset select by bit 9 and bits [11:10] among 0xE7800000, 0xE7C00000, 0xE7900000, 0xE7D00000 (bit 9 = 0) and 0xE18000B0, 0xE19000D0, 0xE19000B0, 0xE19000F0 (bit 9 = 1). Groups 12–15 select by bits [12:11] among 0xE5800000, 0xE5900000, 0xE5C00000, 0xE5D00000 and scale the 5-bit offset by 4 when bit 12 = 0. Both place rd [2:0] at [15:12] and rb [5:3] at [19:16].
- R9: Groups 16/17 expand to 0xE1C000B0 (store) or 0xE1D000B0 (load, bit 11), with bits [8:6] placed at [3:1] and bits [10:9] at [9:8].
- R10: In groups 22/23, bits [11:8] = 0 give a stack adjust: 0xE28DDF00 (add) or 0xE24DDF00 (subtract, bit 7), with bits [6:0] at [6:0]. Codes 4, 5, 12 and 13 give push 0xE92D0000 and pop 0xE8BD0000, with bits [7:0] kept and bit 14 (push) or bit 15 (pop) set when bit 8 = 1.
- R11: Code 14 of groups 22/23 gives 0xE1200070, with bits [7:4] at [11:8] and bits [3:0] kept, only when v5_en_i = 1. It is undefined otherwise. All other codes of those groups are undefined.
- R12: Groups 24/25 expand to 0xE8A00000 (store) or 0xE8B00000 (load, bit 11), with bits [10:8] at [19:16] and bits [7:0] kept.
- R13: Groups 26, 27, 28, 30 and 31 report branch status, except groups 26/27 with bits [11:8] = 14, which are undefined. Group 29 reports branch only when v5_en_i = 1 and bit 0 = 0, and is undefined otherwise.
- R14: status_o encodes 0 = decoded, 1 = undefined, 2 = branch. For status 1 or 2, word_o is 0xDEADC0DE. With the output register, a result appears one cycle after valid_i, with valid_o. Reset clears valid_o, word_o and status_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Fetch word present |
| fetch_i | input | 32 | Two halfwords from fetch |
| big_end_i | input | 1 | Take the upper halfword as current |
| v5_en_i | input | 1 | Enable the feature-gated encodings |
| valid_o | output | 1 | Result present |
| word_o | output | 32 | Expanded instruction or filler |
| status_o | output | 2 | 0 decoded, 1 undefined, 2 branch |

## Verification
Halfword selection and feature gating act in the same cycle. A single fetch word can hold a gated encoding in one half and an ungated one in the other. The bench builds such words and applies them on back-to-back cycles, flipping big_end_i and v5_en_i between cycles. The scoreboard then has to match the result of the selected half only, including its gated outcome. Filler words are checked together with the status, so an undefined or branch result cannot pass with a stale expansion.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int CX_HALF_W  = 16;
  localparam int CX_FETCH_W = 2 * CX_HALF_W;
  localparam int CX_WORD_W  = 32;
  localparam logic [CX_WORD_W-1:0] CX_FILL = 32'hDEADC0DE;

  typedef enum logic [1:0] {
    CX_OK     = 2'd0,
    CX_UNDEF  = 2'd1,
    CX_BRANCH = 2'd2
  } cx_status_e;

  typedef struct packed {
    logic                 hit;
    logic                 undef;
    logic                 br;
    logic [CX_WORD_W-1:0] word;
  } cx_part_t;
endpackage

// File: rtl/cexp_half_sel.sv
module cexp_half_sel #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] fetch_i,
  input  logic                big_end_i,
  output logic [HALF_W-1:0]   half_o
);
  assign half_o = big_end_i ? fetch_i[2*HALF_W-1:HALF_W] : fetch_i[HALF_W-1:0];
endmodule

// File: rtl/cexp_dp_dec.sv
module cexp_dp_dec
  import cexp_pkg::*;
(
  input  logic [CX_HALF_W-1:0] half_i,
  input  logic                 v5_en_i,
  output cx_part_t             part_o
);
  typedef enum logic [1:0] {PL_NORM, PL_SHIFT, PL_NEG, PL_MUL} place_e;

  logic [4:0]  grp;
  logic [2:0]  rd, rs;
  logic [3:0]  sub, hd, hs;
  place_e      pl;
  logic [31:0] alu_base;

  assign grp = half_i[15:11];
  assign rd  = half_i[2:0];
  assign rs  = half_i[5:3];
  assign sub = half_i[9:6];
  assign hd  = {half_i[7], half_i[2:0]};
  assign hs  = {half_i[6], half_i[5:3]};

  always_comb begin
    pl       = PL_NORM;
    alu_base = 32'h0;
    case (sub)
      4'h0: alu_base = 32'hE0100000;
      4'h1: alu_base = 32'hE0300000;
      4'h2: begin alu_base = 32'hE1B00010; pl = PL_SHIFT; end
      4'h3: begin alu_base = 32'hE1B00030; pl = PL_SHIFT; end
      4'h4: begin alu_base = 32'hE1B00050; pl = PL_SHIFT; end
      4'h5: alu_base = 32'hE0B00000;
      4'h6: alu_base = 32'hE0D00000;
      4'h7: begin alu_base = 32'hE1B00070; pl = PL_SHIFT; end
      4'h8: alu_base = 32'hE1100000;
      4'h9: begin alu_base = 32'hE2700000; pl = PL_NEG; end
      4'hA: alu_base = 32'hE1500000;
      4'hB: alu_base = 32'hE1700000;
      4'hC: alu_base = 32'hE1900000;
      4'hD: begin alu_base = 32'hE0100090; pl = PL_MUL; end
      4'hE: alu_base = 32'hE1D00000;
      default: alu_base = 32'hE1F00000;
    endcase
  end

  always_comb begin
    part_o = '0;
    case (grp)
      5'd0, 5'd1, 5'd2: begin
        part_o.hit         = 1'b1;
        part_o.word        = 32'hE1B00000;
        part_o.word[6:5]   = half_i[12:11];
        part_o.word[11:7]  = half_i[10:6];
        part_o.word[3:0]   = {1'b0, rs};
        part_o.word[15:12] = {1'b0, rd};
      end
      5'd3: begin
        part_o.hit = 1'b1;
        case (half_i[10:9])
          2'd0:    part_o.word = 32'hE0900000;
          2'd1:    part_o.word = 32'hE0500000;
          2'd2:    part_o.word = 32'hE2900000;
          default: part_o.word = 32'hE2500000;
        endcase
        part_o.word[3:0]   = {1'b0, half_i[8:6]};
        part_o.word[19:16] = {1'b0, rs};
        part_o.word[15:12] = {1'b0, rd};
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        part_o.hit = 1'b1;
        case (half_i[12:11])
          2'd0:    part_o.word = 32'hE3B00000;
          2'd1:    part_o.word = 32'hE3500000;
          2'd2:    part_o.word = 32'hE2900000;
          default: part_o.word = 32'hE2500000;
        endcase
        part_o.word[7:0]   = half_i[7:0];
        part_o.word[19:16] = {1'b0, half_i[10:8]};
        part_o.word[15:12] = {1'b0, half_i[10:8]};
      end
      5'd8: begin
        part_o.hit = 1'b1;
        if (!half_i[10]) begin
          part_o.word = alu_base;
          case (pl)
            PL_NORM: begin
              part_o.word[19:16] = {1'b0, rd};
              part_o.word[15:12] = {1'b0, rd};
              part_o.word[3:0]   = {1'b0, rs};
            end
            PL_SHIFT: begin
              part_o.word[15:12] = {1'b0, rd};
              part_o.word[3:0]   = {1'b0, rd};
              part_o.word[11:8]  = {1'b0, rs};
            end
            PL_NEG: begin
              part_o.word[15:12] = {1'b0, rd};
              part_o.word[19:16] = {1'b0, rs};
            end
            default: begin
              part_o.word[19:16] = {1'b0, rd};
              part_o.word[11:8]  = {1'b0, rd};
              part_o.word[3:0]   = {1'b0, rs};
            end
          endcase
        end else begin
          case (sub)
            4'h1, 4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'h9, 4'hA, 4'hB: begin
              case (sub[3:2])
                2'd0:    part_o.word = 32'hE0800000;
                2'd1:    part_o.word = 32'hE1500000;
                default: part_o.word = 32'hE1A00000;
              endcase
              part_o.word[19:16] = hd;
              part_o.word[15:12] = hd;
              part_o.word[3:0]   = hs;
            end
            4'hC, 4'hD: begin
              part_o.word      = 32'hE12FFF10;
              part_o.word[3:0] = half_i[6:3];
            end
            4'hE, 4'hF: begin
              // exchange-with-link form is option gated
              if (v5_en_i) begin
                part_o.word      = 32'hE12FFF30;
                part_o.word[3:0] = half_i[6:3];
              end else begin
                part_o.undef = 1'b1;
              end
            end
            default: part_o.undef = 1'b1;
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cexp_ls_dec.sv
module cexp_ls_dec
  import cexp_pkg::*;
(
  input  logic [CX_HALF_W-1:0] half_i,
  input  logic                 v5_en_i,
  output cx_part_t             part_o
);
  logic [4:0] grp;
  logic [2:0] rd, rb;

  assign grp = half_i[15:11];
  assign rd  = half_i[2:0];
  assign rb  = half_i[5:3];

  always_comb begin
    part_o = '0;
    case (grp)
      5'd9, 5'd18, 5'd19: begin
        part_o.hit = 1'b1;
        if (grp == 5'd9)      part_o.word = 32'hE59F0000;
        else if (half_i[11])  part_o.word = 32'hE59D0000;
        else                  part_o.word = 32'hE58D0000;
        part_o.word[15:12] = {1'b0, half_i[10:8]};
        part_o.word[9:2]   = half_i[7:0];
      end
      5'd10, 5'd11: begin
        part_o.hit = 1'b1;
        case ({half_i[9], half_i[11:10]})
          3'd0:    part_o.word = 32'hE7800000;
          3'd1:    part_o.word = 32'hE7C00000;
          3'd2:    part_o.word = 32'hE7900000;
          3'd3:    part_o.word = 32'hE7D00000;
          3'd4:    part_o.word = 32'hE18000B0;
          3'd5:    part_o.word = 32'hE19000D0;
          3'd6:    part_o.word = 32'hE19000B0;
          default: part_o.word = 32'hE19000F0;
        endcase
        part_o.word[15:12] = {1'b0, rd};
        part_o.word[19:16] = {1'b0, rb};
        part_o.word[3:0]   = {1'b0, half_i[8:6]};
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        part_o.hit = 1'b1;
        case (half_i[12:11])
          2'd0:    part_o.word = 32'hE5800000;
          2'd1:    part_o.word = 32'hE5900000;
          2'd2:    part_o.word = 32'hE5C00000;
          default: part_o.word = 32'hE5D00000;
        endcase
        part_o.word[15:12] = {1'b0, rd};
        part_o.word[19:16] = {1'b0, rb};
        // word transfers scale by 4, byte transfers do not
        if (half_i[12]) part_o.word[4:0] = half_i[10:6];
        else            part_o.word[6:2] = half_i[10:6];
      end
      5'd16, 5'd17: begin
        part_o.hit         = 1'b1;
        part_o.word        = half_i[11] ? 32'hE1D000B0 : 32'hE1C000B0;
        part_o.word[15:12] = {1'b0, rd};
        part_o.word[19:16] = {1'b0, rb};
        part_o.word[3:1]   = half_i[8:6];
        part_o.word[9:8]   = half_i[10:9];
      end
      5'd20, 5'd21: begin
        part_o.hit         = 1'b1;
        part_o.word        = half_i[11] ? 32'hE28D0F00 : 32'hE28F0F00;
        part_o.word[15:12] = {1'b0, half_i[10:8]};
        part_o.word[7:0]   = half_i[7:0];
      end
      5'd22, 5'd23: begin
        part_o.hit = 1'b1;
        case (half_i[11:8])
          4'h0: begin
            part_o.word      = half_i[7] ? 32'hE24DDF00 : 32'hE28DDF00;
            part_o.word[6:0] = half_i[6:0];
          end
          4'h4, 4'h5: begin
            part_o.word      = 32'hE92D0000;
            part_o.word[14]  = half_i[8];
            part_o.word[7:0] = half_i[7:0];
          end
          4'hC, 4'hD: begin
            part_o.word      = 32'hE8BD0000;
            part_o.word[15]  = half_i[8];
            part_o.word[7:0] = half_i[7:0];
          end
          4'hE: begin
            if (v5_en_i) begin
              part_o.word       = 32'hE1200070;
              part_o.word[11:8] = half_i[7:4];
              part_o.word[3:0]  = half_i[3:0];
            end else begin
              part_o.undef = 1'b1;
            end
          end
          default: part_o.undef = 1'b1;
        endcase
      end
      5'd24, 5'd25: begin
        part_o.hit         = 1'b1;
        part_o.word        = half_i[11] ? 32'hE8B00000 : 32'hE8A00000;
        part_o.word[19:16] = {1'b0, half_i[10:8]};
        part_o.word[7:0]   = half_i[7:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cexp_br_dec.sv
module cexp_br_dec
  import cexp_pkg::*;
(
  input  logic [4:0] grp_i,
  input  logic [3:0] cond_i,
  input  logic       lsb_i,
  input  logic       v5_en_i,
  output cx_part_t   part_o
);
  always_comb begin
    part_o = '0;
    case (grp_i)
      5'd26, 5'd27: begin
        part_o.hit   = 1'b1;
        part_o.undef = (cond_i == 4'hE);
        part_o.br    = (cond_i != 4'hE);
      end
      5'd28, 5'd30, 5'd31: begin
        part_o.hit = 1'b1;
        part_o.br  = 1'b1;
      end
      5'd29: begin
        part_o.hit   = 1'b1;
        part_o.br    = v5_en_i && !lsb_i;
        part_o.undef = !(v5_en_i && !lsb_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cinstr_expander.sv
module cinstr_expander
  import cexp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [CX_FETCH_W-1:0] fetch_i,
  input  logic                  big_end_i,
  input  logic                  v5_en_i,
  output logic                  valid_o,
  output logic [CX_WORD_W-1:0]  word_o,
  output logic [1:0]            status_o
);
  localparam int N_PART = 3;

  logic [CX_HALF_W-1:0] half;
  cx_part_t             parts [N_PART];
  logic [CX_WORD_W-1:0] word_d;
  cx_status_e           st_d;

  cexp_half_sel #(.HALF_W(CX_HALF_W)) u_sel (
    .fetch_i   (fetch_i),
    .big_end_i (big_end_i),
    .half_o    (half)
  );

  cexp_dp_dec u_dp (.half_i(half), .v5_en_i(v5_en_i), .part_o(parts[0]));
  cexp_ls_dec u_ls (.half_i(half), .v5_en_i(v5_en_i), .part_o(parts[1]));
  cexp_br_dec u_br (
    .grp_i   (half[15:11]),
    .cond_i  (half[11:8]),
    .lsb_i   (half[0]),
    .v5_en_i (v5_en_i),
    .part_o  (parts[2])
  );

  // groups are disjoint: at most one decoder hits
  always_comb begin
    logic any_hit, any_undef, any_br;
    logic [CX_WORD_W-1:0] w;
    any_hit   = 1'b0;
    any_undef = 1'b0;
    any_br    = 1'b0;
    w         = '0;
    for (int i = 0; i < N_PART; i++) begin
      any_hit   |= parts[i].hit;
      any_undef |= parts[i].hit & parts[i].undef;
      any_br    |= parts[i].hit & parts[i].br;
      w         |= parts[i].hit ? parts[i].word : '0;
    end
    if (any_undef || !any_hit) begin
      st_d   = CX_UNDEF;
      word_d = CX_FILL;
    end else if (any_br) begin
      st_d   = CX_BRANCH;
      word_d = CX_FILL;
    end else begin
      st_d   = CX_OK;
      word_d = w;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o  <= 1'b0;
          word_o   <= '0;
          status_o <= '0;
        end else begin
          valid_o  <= valid_i;
          word_o   <= word_d;
          status_o <= st_d;
        end
      end
    end else begin : g_comb
      assign valid_o  = valid_i;
      assign word_o   = word_d;
      assign status_o = st_d;
    end
  endgenerate
endmodule

// File: rtl/cexp_chk.sv
module cexp_chk
  import cexp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [CX_FETCH_W-1:0] fetch_i,
  input logic                  big_end_i,
  input logic                  v5_en_i,
  input logic                  valid_o,
  input logic [CX_WORD_W-1:0]  word_o,
  input logic [1:0]            status_o
);
  logic                 armed;
  logic [CX_HALF_W-1:0] cur;

  assign cur = big_end_i ? fetch_i[CX_FETCH_W-1:CX_HALF_W] : fetch_i[CX_HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R14
  undef_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && status_o == 2'd1 |-> word_o == CX_FILL);

  // R13
  branch_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && status_o == 2'd2 |-> word_o == CX_FILL);

  // R14
  status_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> status_o != 2'd3);

  generate
    if (REG_OUT) begin : g_seq
      // R14
      latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> valid_o == $past(valid_i));

      // R11
      bkpt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && $past(valid_i && !v5_en_i && cur[15:8] == 8'hBE) |-> status_o == 2'd1);

      // R6
      xlink_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && $past(valid_i && !v5_en_i && cur[15:7] == 9'b0100_0111_1) |-> status_o == 2'd1);
    end
  endgenerate
endmodule

bind cinstr_expander cexp_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .fetch_i   (fetch_i),
  .big_end_i (big_end_i),
  .v5_en_i   (v5_en_i),
  .valid_o   (valid_o),
  .word_o    (word_o),
  .status_o  (status_o)
);

// File: tb/cinstr_expander_test.sv
`timescale 1ns/1ps
module cinstr_expander_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] fetch_i = '0;
  logic        big_end_i = 1'b0;
  logic        v5_en_i = 1'b0;
  logic        valid_o;
  logic [31:0] word_o;
  logic [1:0]  status_o;

  localparam logic [31:0] FILL = 32'hDEADC0DE;
  localparam logic [1:0] S_OK = 2'd0, S_UN = 2'd1, S_BR = 2'd2;

  typedef struct {
    logic [31:0] w;
    logic [1:0]  st;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  cinstr_expander uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .fetch_i   (fetch_i),
    .big_end_i (big_end_i),
    .v5_en_i   (v5_en_i),
    .valid_o   (valid_o),
    .word_o    (word_o),
    .status_o  (status_o)
  );

  task automatic push(input logic [31:0] fw, input logic be, input logic v5,
                      input logic [31:0] ew, input logic [1:0] est, input string tag);
    exp_t e;
    @(negedge clk_i);
    fetch_i   = fw;
    big_end_i = be;
    v5_en_i   = v5;
    valid_i   = 1'b1;
    e.w = ew; e.st = est; e.tag = tag;
    sbq.push_back(e);
  endtask

  // current halfword in the low half, inverted copy in the upper half
  task automatic lo(input logic [15:0] h, input logic v5,
                    input logic [31:0] ew, input logic [1:0] est, input string tag);
    push({~h, h}, 1'b0, v5, ew, est, tag);
  endtask

  task automatic hi(input logic [15:0] h, input logic [15:0] other, input logic v5,
                    input logic [31:0] ew, input logic [1:0] est, input string tag);
    push({h, other}, 1'b1, v5, ew, est, tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor: result appears one cycle after the driving edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && valid_o && !done) begin
      exp_t e;
      n_run++;
      if (sbq.size() == 0) begin
        n_fail++;
        $display("FAIL R14 unexpected output word=%h status=%0d expected none", word_o, status_o);
      end else begin
        e = sbq.pop_front();
        if (word_o !== e.w || status_o !== e.st) begin
          n_fail++;
          $display("FAIL %s actual word=%h status=%0d expected word=%h status=%0d",
                   e.tag, word_o, status_o, e.w, e.st);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_run++;
    if (valid_o !== 1'b0 || word_o !== 32'h0 || status_o !== 2'd0) begin
      n_fail++;
      $display("FAIL R14 reset actual v=%b w=%h s=%0d expected v=0 w=0 s=0",
               valid_o, word_o, status_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 shifts
    lo(16'h00D1, 1'b0, 32'hE1B01182, S_OK, "R2 lsl imm");
    lo(16'h17C7, 1'b0, 32'hE1B07FC0, S_OK, "R2 asr imm");
    // R3 add/sub
    lo(16'h1F63, 1'b0, 32'hE2543005, S_OK, "R3 sub imm3");
    lo(16'h1888, 1'b0, 32'hE0910002, S_OK, "R3 add reg");
    // R4 imm8
    lo(16'h2D80, 1'b0, 32'hE3555080, S_OK, "R4 cmp imm8");
    lo(16'h22FF, 1'b0, 32'hE3B220FF, S_OK, "R4 mov imm8");
    // R5 register ALU classes
    lo(16'h4073, 1'b0, 32'hE0333006, S_OK, "R5 normal");
    lo(16'h41EA, 1'b0, 32'hE1B02572, S_OK, "R5 shift");
    lo(16'h4261, 1'b0, 32'hE2741000, S_OK, "R5 negate");
    lo(16'h437E, 1'b0, 32'hE0160697, S_OK, "R5 multiply");
    // R6 high registers
    lo(16'h44CA, 1'b0, 32'hE08AA009, S_OK, "R6 add hi/hi");
    lo(16'h4660, 1'b0, 32'hE1A0000C, S_OK, "R6 mov hs");
    lo(16'h4770, 1'b0, 32'hE12FFF1E, S_OK, "R6 exchange");
    lo(16'h4798, 1'b1, 32'hE12FFF33, S_OK, "R6 xlink v5 on");
    lo(16'h4798, 1'b0, FILL, S_UN, "R6 xlink v5 off");
    lo(16'h440A, 1'b1, FILL, S_UN, "R6 sub0 undef");
    lo(16'h4500, 1'b1, FILL, S_UN, "R6 sub4 undef");
    lo(16'h4600, 1'b1, FILL, S_UN, "R6 sub8 undef");
    // R7 PC/SP relative
    lo(16'h4B10, 1'b0, 32'hE59F3040, S_OK, "R7 pc load");
    lo(16'h967F, 1'b0, 32'hE58D61FC, S_OK, "R7 sp store");
    lo(16'hA120, 1'b0, 32'hE28F1F20, S_OK, "R7 add pc");
    lo(16'hAFFF, 1'b0, 32'hE28D7FFF, S_OK, "R7 add sp");
    // R8 register and immediate offsets
    lo(16'h5CA9, 1'b0, 32'hE7D51002, S_OK, "R8 ldrb reg");
    lo(16'h5FC4, 1'b0, 32'hE19040F7, S_OK, "R8 ldrsh reg");
    lo(16'h5253, 1'b0, 32'hE18230B1, S_OK, "R8 strh reg");
    lo(16'h694A, 1'b0, 32'hE5912014, S_OK, "R8 word scaled");
    lo(16'h77F8, 1'b0, 32'hE5C7001F, S_OK, "R8 byte unscaled");
    // R9 halfword immediate split
    lo(16'h8D9D, 1'b0, 32'hE1D352BC, S_OK, "R9 half split");
    // R10 stack adjust, push/pop
    lo(16'hB085, 1'b0, 32'hE24DDF05, S_OK, "R10 sp sub");
    lo(16'hB07F, 1'b0, 32'hE28DDF7F, S_OK, "R10 sp add");
    lo(16'hB5F0, 1'b0, 32'hE92D40F0, S_OK, "R10 push lr");
    lo(16'hB403, 1'b0, 32'hE92D0003, S_OK, "R10 push");
    lo(16'hBD11, 1'b0, 32'hE8BD8011, S_OK, "R10 pop pc");
    lo(16'hBC80, 1'b0, 32'hE8BD0080, S_OK, "R10 pop");
    // R11 breakpoint gating
    lo(16'hBEAB, 1'b1, 32'hE1200A7B, S_OK, "R11 bkpt v5 on");
    lo(16'hBEAB, 1'b0, FILL, S_UN, "R11 bkpt v5 off");
    lo(16'hB100, 1'b1, FILL, S_UN, "R11 misc undef");
    // R12 multiple
    lo(16'hCB0F, 1'b0, 32'hE8B3000F, S_OK, "R12 load multiple");
    lo(16'hC0FF, 1'b0, 32'hE8A000FF, S_OK, "R12 store multiple");
    // R13 branch status
    lo(16'hD012, 1'b0, FILL, S_BR, "R13 cond branch");
    lo(16'hDE00, 1'b0, FILL, S_UN, "R13 cond 14 undef");
    lo(16'hDF05, 1'b0, FILL, S_BR, "R13 cond 15");
    lo(16'hE7FE, 1'b0, FILL, S_BR, "R13 uncond");
    lo(16'hF000, 1'b0, FILL, S_BR, "R13 long first");
    lo(16'hF800, 1'b0, FILL, S_BR, "R13 long second");
    lo(16'hE800, 1'b1, FILL, S_BR, "R13 grp29 v5");
    lo(16'hE801, 1'b1, FILL, S_UN, "R13 grp29 odd");
    lo(16'hE800, 1'b0, FILL, S_UN, "R13 grp29 no v5");
    // R1 endianness with a conflicting other half, alternating gating
    hi(16'h00D1, 16'hBEAB, 1'b1, 32'hE1B01182, S_OK, "R1 upper selected");
    lo(16'hBEAB, 1'b1, 32'hE1200A7B, S_OK, "R1 lower selected");
    hi(16'hBEAB, 16'h00D1, 1'b0, FILL, S_UN, "R1 upper gated off");
    push({16'h4798, 16'h1888}, 1'b0, 1'b0, 32'hE0910002, S_OK, "R1 lower ignores upper");
    push({16'h4798, 16'h1888}, 1'b1, 1'b1, 32'hE12FFF33, S_OK, "R1 upper gated on");
    idle();
    repeat (3) @(negedge clk_i);

    // R14 output idle after valid drops
    n_run++;
    if (valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R14 idle actual v=%b expected v=0", valid_o);
    end
    n_run++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL R14 missing results actual %0d pending expected 0", sbq.size());
    end
    finish_run();
  end
endmodule